// File: doc/BRIEF.md
# UART Modem and Data Loopback Path

This block sits between a UART's register file, its receive buffer and the outside world. It has two modes, chosen by one bit of the control word. In normal mode the four modem status flags follow the external status pins through a two-flop synchronizer, and received characters and line breaks from the external receiver are forwarded into the receive buffer. In loopback mode the external receive side is cut off. The four modem control outputs of the control word are fed back crosswise as modem status. Every transmitted byte, and every newly raised break request, becomes a receive-buffer entry.

The block also drives the modem part of the flag register and four level-type raw interrupt bits. The buffer sees at most one push per cycle. A break that collides with a data push waits for the next free cycle. A waiting break is discarded when the mode changes. All outputs are registered.

Top module: `uart_loopback_path`

## Requirements
- R1: After reset the flag outputs, the interrupt levels and the push strobe are all zero.
- R2: With the loopback bit (control bit 7) set, the output register loaded at a clock edge holds RI = control bit 13, DCD = control bit 12, CTS = control bit 11 and DSR = control bit 10.
- R3: Setting the loopback bit alone, with modem control bits already set, updates the flags at the next edge.
- R4: With loopback clear, each modem flag equals its external pin as it was three edges earlier (two synchronizer stages plus the output register).
- R5: `fr_modem` carries RI at bit 8, DCD at bit 2, DSR at bit 1 and CTS at bit 0, and all its other bits are zero.
- R6: `int_modem` mirrors the flags as levels: bit 3 DSR, bit 2 DCD, bit 1 CTS, bit 0 RI.
- R7: In loopback, a byte with `tx_valid` high at an edge is pushed at that edge as an entry with bit 10 clear and the byte in bits 7:0.
- R8: In loopback, external receive data, external break events and the external modem pins cause no push and no flag change.
- R9: In loopback, a 0-to-1 change of `brk_en` pushes a break entry (bit 10 set, bits 7:0 zero). A falling or steady `brk_en` pushes nothing.
- R10: With loopback clear, external data is pushed as a data entry and an external break is pushed as a break entry, while `tx_valid` pushes nothing.
- R11: When a break request and a data push fall on the same edge, the data goes first and the break is pushed at the next edge that has no data, so there is never more than one push per edge.
- R12: A deferred break is discarded when the loopback bit changes before that break is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reg | input | 16 | Control word: bit 7 loopback, 10 DTR, 11 RTS, 12 OUT1, 13 OUT2 |
| brk_en | input | 1 | Break-enable bit of line control |
| ext_ri | input | 1 | External ring indicator pin |
| ext_dcd | input | 1 | External carrier detect pin |
| ext_dsr | input | 1 | External data set ready pin |
| ext_cts | input | 1 | External clear to send pin |
| ext_rx_valid | input | 1 | External receiver has a character |
| ext_rx_data | input | 8 | External received character |
| ext_brk | input | 1 | External receiver detected a break |
| tx_valid | input | 1 | Byte written for transmit |
| tx_data | input | 8 | Transmit byte |
| fr_modem | output | 9 | Modem bits of the flag register |
| int_modem | output | 4 | Modem raw interrupt levels |
| rxq_push | output | 1 | Push strobe into the receive buffer |
| rxq_entry | output | 11 | Entry pushed: bit 10 break, bits 7:0 data |

## Verification
A wrong mode select shows up one edge after a control write. The flags then show pin values where they should show control bits, or the reverse. A stray or missing push appears as a mismatch on the next strobe. A wrong synchronizer depth shifts the external flag edge by one cycle, and it is caught by sampling both two and three edges after a pin change. A stale deferred-break bit surfaces as an unexpected break entry on the first idle edge after the collision, or after a mode change.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    localparam int LB_POS   = 7;
    localparam int DTR_POS  = 10;
    localparam int RTS_POS  = 11;
    localparam int OUT1_POS = 12;
    localparam int OUT2_POS = 13;

    localparam int FR_RI_POS  = 8;
    localparam int FR_DCD_POS = 2;
    localparam int FR_DSR_POS = 1;
    localparam int FR_CTS_POS = 0;

    typedef struct packed {
        logic ri;
        logic dcd;
        logic dsr;
        logic cts;
    } modem_t;
endpackage

// File: rtl/lb_sync2.sv
module lb_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/lb_modem_sel.sv
module lb_modem_sel
    import uart_lb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lb_en,
    input  modem_t loop_src,
    input  modem_t ext_sync,
    output modem_t flags
);
    typedef struct packed {
        modem_t flags;
        logic   hist;
    } sel_t;

    sel_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.hist  = 1'b1;
        st_d.flags = lb_en ? loop_src : ext_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R2 / R3: looped values land one edge after the control word shows loopback
    a_r2_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hist && $past(lb_en)) |-> (flags == $past(loop_src)));
endmodule

// File: rtl/lb_push_sel.sv
module lb_push_sel #(
    parameter int DATA_W  = 8,
    parameter int BRK_POS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_en,
    input  logic              brk_en,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              push,
    output logic [BRK_POS:0]  entry
);
    localparam int ENTRY_W = BRK_POS + 1;

    typedef struct packed {
        logic               push;
        logic [ENTRY_W-1:0] entry;
        logic               brk_prev;
        logic               lb_prev;
        logic               pend;
        logic               hist;
    } push_t;

    push_t st_d, st_q;

    logic              brk_rise;
    logic              mode_chg;
    logic              data_v;
    logic [DATA_W-1:0] data_sel;
    logic              brk_req;
    logic              pend_base;

    always_comb begin
        brk_rise  = brk_en & ~st_q.brk_prev;
        mode_chg  = lb_en ^ st_q.lb_prev;
        data_v    = lb_en ? tx_valid : ext_rx_valid;
        data_sel  = lb_en ? tx_data : ext_rx_data;
        brk_req   = lb_en ? brk_rise : ext_brk;
        pend_base = mode_chg ? 1'b0 : st_q.pend;

        st_d          = st_q;
        st_d.hist     = 1'b1;
        st_d.brk_prev = brk_en;
        st_d.lb_prev  = lb_en;
        st_d.push     = 1'b0;
        st_d.entry    = '0;
        st_d.pend     = pend_base;

        if (data_v) begin
            st_d.push                 = 1'b1;
            st_d.entry[DATA_W-1:0]    = data_sel;
            st_d.pend                 = pend_base | brk_req;
        end else if (pend_base | brk_req) begin
            st_d.push                 = 1'b1;
            st_d.entry[BRK_POS]       = 1'b1;
            st_d.pend                 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push  = st_q.push;
    assign entry = st_q.entry;

    // R7: a looped data entry carries the byte presented for transmit
    a_r7_tx_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hist && push && !entry[BRK_POS] && $past(lb_en))
        |-> ($past(tx_valid) && entry[DATA_W-1:0] == $past(tx_data)));

    // R10: a data entry outside loopback comes from the external receiver
    a_r10_ext_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hist && push && !entry[BRK_POS] && !$past(lb_en))
        |-> ($past(ext_rx_valid) && entry[DATA_W-1:0] == $past(ext_rx_data)));

    // R9: a raised break request with no data pending is pushed at once
    a_r9_brk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_en && brk_en && !st_q.brk_prev && !tx_valid)
        |=> (push && entry[BRK_POS]));
endmodule

// File: rtl/uart_loopback_path.sv
module uart_loopback_path
    import uart_lb_pkg::*;
#(
    parameter int CTRL_W  = 16,
    parameter int DATA_W  = 8,
    parameter int FLAG_W  = 9,
    parameter int BRK_POS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_reg,
    input  logic              brk_en,
    input  logic              ext_ri,
    input  logic              ext_dcd,
    input  logic              ext_dsr,
    input  logic              ext_cts,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [FLAG_W-1:0] fr_modem,
    output logic [3:0]        int_modem,
    output logic              rxq_push,
    output logic [BRK_POS:0]  rxq_entry
);
    logic   lb_en;
    modem_t loop_src;
    modem_t ext_raw;
    modem_t ext_sync;
    modem_t flags;
    logic   ctrl_unused;

    assign lb_en        = ctrl_reg[LB_POS];
    assign loop_src.ri  = ctrl_reg[OUT2_POS];
    assign loop_src.dcd = ctrl_reg[OUT1_POS];
    assign loop_src.cts = ctrl_reg[RTS_POS];
    assign loop_src.dsr = ctrl_reg[DTR_POS];
    assign ctrl_unused  = ^{ctrl_reg[CTRL_W-1:OUT2_POS+1], ctrl_reg[DTR_POS-1:LB_POS+1],
                            ctrl_reg[LB_POS-1:0]};

    assign ext_raw = '{ri: ext_ri, dcd: ext_dcd, dsr: ext_dsr, cts: ext_cts};

    lb_sync2 #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_raw),
        .dout  (ext_sync)
    );

    lb_modem_sel u_modem (
        .clk      (clk),
        .rst_n    (rst_n),
        .lb_en    (lb_en),
        .loop_src (loop_src),
        .ext_sync (ext_sync),
        .flags    (flags)
    );

    lb_push_sel #(.DATA_W(DATA_W), .BRK_POS(BRK_POS)) u_push (
        .clk          (clk),
        .rst_n        (rst_n),
        .lb_en        (lb_en),
        .brk_en       (brk_en),
        .ext_rx_valid (ext_rx_valid),
        .ext_rx_data  (ext_rx_data),
        .ext_brk      (ext_brk),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .push         (rxq_push),
        .entry        (rxq_entry)
    );

    always_comb begin
        fr_modem             = '0;
        fr_modem[FR_RI_POS]  = flags.ri;
        fr_modem[FR_DCD_POS] = flags.dcd;
        fr_modem[FR_DSR_POS] = flags.dsr;
        fr_modem[FR_CTS_POS] = flags.cts;
    end

    assign int_modem = {flags.dsr, flags.dcd, flags.cts, flags.ri};

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R4: external path is three edges deep
    a_r4_ext_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(lb_en))
        |-> (fr_modem[FR_CTS_POS] == $past(ext_cts, 3) && fr_modem[FR_RI_POS] == $past(ext_ri, 3)));

    // R6: interrupt levels track the flag bits
    a_r6_int_level: assert property (@(posedge clk) disable iff (!rst_n)
        int_modem == {fr_modem[FR_DSR_POS], fr_modem[FR_DCD_POS],
                      fr_modem[FR_CTS_POS], fr_modem[FR_RI_POS]});
endmodule

// File: tb/test_uart_loopback_path.sv
module test_uart_loopback_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_reg = '0;
    logic        brk_en = 1'b0;
    logic        ext_ri = 1'b0, ext_dcd = 1'b0, ext_dsr = 1'b0, ext_cts = 1'b0;
    logic        ext_rx_valid = 1'b0;
    logic [7:0]  ext_rx_data = '0;
    logic        ext_brk = 1'b0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [8:0]  fr_modem;
    logic [3:0]  int_modem;
    logic        rxq_push;
    logic [10:0] rxq_entry;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    logic [10:0] exp_q[$];

    always #5 clk = ~clk;

    uart_loopback_path i_uart_loopback_path (
        .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .brk_en(brk_en),
        .ext_ri(ext_ri), .ext_dcd(ext_dcd), .ext_dsr(ext_dsr), .ext_cts(ext_cts),
        .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
        .tx_valid(tx_valid), .tx_data(tx_data), .fr_modem(fr_modem),
        .int_modem(int_modem), .rxq_push(rxq_push), .rxq_entry(rxq_entry)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [15:0] mk_ctrl(input logic lb, input logic o2, input logic o1,
                                            input logic rts, input logic dtr);
        logic [15:0] c = '0;
        c[7] = lb; c[13] = o2; c[12] = o1; c[11] = rts; c[10] = dtr;
        return c;
    endfunction

    task automatic check_modem(input string req, input logic ri, input logic dcd,
                               input logic dsr, input logic cts);
        logic [8:0] ef;
        logic [3:0] ei;
        ef = '0; ef[8] = ri; ef[2] = dcd; ef[1] = dsr; ef[0] = cts;
        ei = {dsr, dcd, cts, ri};
        n_tests++;
        if (fr_modem !== ef || int_modem !== ei) begin
            n_fail++;
            $display("FAIL %s: flags=%h int=%h expected flags=%h int=%h", req, fr_modem, int_modem, ef, ei);
        end
    endtask

    task automatic check_empty(input string req);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d pushes missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    // monitor: compare every push against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rxq_push) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected push entry=%h expected no push", cur_req, rxq_entry);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                if (rxq_entry !== e) begin
                    n_fail++;
                    $display("FAIL %s: entry=%h expected %h", cur_req, rxq_entry, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        n_tests++;
        if (fr_modem !== '0 || int_modem !== '0 || rxq_push !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: flags=%h int=%h push=%b expected 0", fr_modem, int_modem, rxq_push);
        end
        rst_n = 1'b1;
        tick(2);

        // R4: external pins, check latency two vs three edges
        cur_req = "R4";
        ext_cts = 1'b1; ext_ri = 1'b1;
        tick(2);
        check_modem("R4", 0, 0, 0, 0);
        tick(1);
        check_modem("R4", 1, 0, 0, 1);
        ext_ri = 1'b0; ext_cts = 1'b0; ext_dcd = 1'b1; ext_dsr = 1'b1;
        tick(3);
        check_modem("R5", 0, 1, 1, 0);
        ext_dcd = 1'b0; ext_dsr = 1'b0;
        tick(3);
        check_modem("R4", 0, 0, 0, 0);

        // R3: modem bits set first, loopback bit later
        cur_req = "R3";
        ctrl_reg = mk_ctrl(0, 1, 0, 1, 0);
        tick(1);
        check_modem("R3", 0, 0, 0, 0);
        ctrl_reg = mk_ctrl(1, 1, 0, 1, 0);
        tick(1);
        check_modem("R3", 1, 0, 0, 1);

        // R2 / R6: crosswise patterns
        cur_req = "R2";
        ctrl_reg = mk_ctrl(1, 0, 1, 0, 1);
        tick(1);
        check_modem("R2", 0, 1, 1, 0);
        ctrl_reg = mk_ctrl(1, 1, 1, 1, 1);
        tick(1);
        check_modem("R6", 1, 1, 1, 1);
        ctrl_reg = mk_ctrl(1, 0, 0, 0, 0);
        tick(1);
        check_modem("R2", 0, 0, 0, 0);

        // R8: external stimulus ignored in loopback
        cur_req = "R8";
        ext_ri = 1; ext_dcd = 1; ext_dsr = 1; ext_cts = 1;
        ext_rx_valid = 1; ext_rx_data = 8'h5A; ext_brk = 1;
        tick(1);
        ext_rx_valid = 0; ext_brk = 0;
        tick(4);
        check_modem("R8", 0, 0, 0, 0);
        check_empty("R8");
        ext_ri = 0; ext_dcd = 0; ext_dsr = 0; ext_cts = 0;

        // R7: transmitted bytes loop back
        cur_req = "R7";
        tx_valid = 1; tx_data = 8'hA5; exp_q.push_back(11'h0A5);
        tick(1);
        tx_data = 8'h3C; exp_q.push_back(11'h03C);
        tick(1);
        tx_valid = 0;
        tick(2);
        check_empty("R7");

        // R9: break rise pushes once, fall pushes nothing
        cur_req = "R9";
        brk_en = 1; exp_q.push_back(11'h400);
        tick(3);
        brk_en = 0;
        tick(3);
        check_empty("R9");

        // R11: collision, data first then break
        cur_req = "R11";
        tx_valid = 1; tx_data = 8'h77; brk_en = 1;
        exp_q.push_back(11'h077); exp_q.push_back(11'h400);
        tick(1);
        tx_valid = 0;
        tick(3);
        check_empty("R11");
        brk_en = 0;
        tick(1);

        // R12: deferred break dropped on mode change
        cur_req = "R12";
        tx_valid = 1; tx_data = 8'h12; brk_en = 1; exp_q.push_back(11'h012);
        tick(1);
        tx_valid = 0; ctrl_reg = mk_ctrl(0, 0, 0, 0, 0);
        tick(4);
        check_empty("R12");
        brk_en = 0;

        // R10: normal mode pushes external data and breaks, not tx
        cur_req = "R10";
        tx_valid = 1; tx_data = 8'h99;
        tick(1);
        tx_valid = 0;
        brk_en = 1;
        tick(2);
        brk_en = 0;
        check_empty("R10");
        ext_rx_valid = 1; ext_rx_data = 8'hC3; exp_q.push_back(11'h0C3);
        tick(1);
        ext_rx_valid = 0; ext_brk = 1; exp_q.push_back(11'h400);
        tick(1);
        ext_brk = 0;
        tick(2);
        check_empty("R10");

        // R11 in normal mode: data and break together
        cur_req = "R11";
        ext_rx_valid = 1; ext_rx_data = 8'h01; ext_brk = 1;
        exp_q.push_back(11'h001); exp_q.push_back(11'h400);
        tick(1);
        ext_rx_valid = 0; ext_brk = 0;
        tick(3);
        check_empty("R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule